// File: doc/BRIEF.md
# Dual-Channel Conversion Sequencer

This block paces a converter that takes two samples, one per channel, for every start command. A start pulse received while idle raises a busy flag and asks the conversion engine for a channel-0 result. When the engine answers with its done handshake, the block stores that result. It then asks for channel 1. When the second answer arrives, both halves are written into a 32-bit readout word. On that same clock edge busy drops and a one-cycle load strobe goes to the serial port logic.

Each completed channel conversion produces one low pulse, one cycle long, on the end-of-conversion output. The host can therefore follow both channels, or it can simply wait for the falling edge of busy. A synchronous active-high reset abandons any sequence in progress and returns the block to idle.

Top module: `dual_conv_seq`

## Requirements
- R1: When `start_i` is high, busy is low and reset is low, `busy_o` and `conv_req_o` are both high on the next cycle, and `conv_sel_o` is 0 (channel 0).
- R2: Once raised, `busy_o` stays high until the engine has answered twice. It goes low in the cycle after the second `conv_done_i` is sampled.
- R3: Each `conv_done_i` sampled during busy drives `eoc_n_o` low for exactly one cycle, starting on the next cycle. A full sequence therefore gives two such pulses.
- R4: The first answer's data goes into `result_o[31:16]` and the second answer's data into `result_o[15:0]`. `result_o` changes only in the cycle where busy falls, and `load_o` is high for that single cycle.
- R5: A start pulse that arrives while busy is high has no effect. No extra request is issued, no extra pulse appears and the word is not changed.
- R6: A `conv_done_i` pulse while idle has no effect. Busy, `eoc_n_o`, `load_o` and `result_o` are all unchanged.
- R7: While reset is high, on the next cycle `busy_o` is 0, `eoc_n_o` is 1, `load_o` and `conv_req_o` are 0, `conv_sel_o` is 0 and `result_o` is 0. Any conversion in progress is abandoned.
- R8: The cycle after the first answer is sampled, `conv_req_o` pulses for one cycle with `conv_sel_o` at 1 (channel 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start-sequence pulse |
| conv_done_i | input | 1 | Engine answer strobe, one cycle |
| conv_data_i | input | 16 | Engine result, valid with `conv_done_i` |
| conv_req_o | output | 1 | One-cycle request to the engine |
| conv_sel_o | output | 1 | Channel of the current request (0 or 1) |
| busy_o | output | 1 | High for the whole two-channel sequence |
| eoc_n_o | output | 1 | Active-low per-channel completion pulse |
| result_o | output | 32 | Latched pair of results |
| load_o | output | 1 | One-cycle strobe when `result_o` is refreshed |

## Verification
The hardest case to reach from the ports is a reset that lands while the block waits for the channel-1 answer. The engine model has already been given a request and would answer after the reset is gone. The stimulus issues a start with a long engine latency, waits for the channel-1 request, raises reset, and then lets the stale answer arrive while the block is idle. This checks that no pulse, load or word change follows. The bench also exercises start pulses during busy, done pulses with no request, and several engine latencies, down to an answer in the cycle right after the request.

// File: rtl/dual_conv_seq_pkg.sv
package dual_conv_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CH0  = 2'd1,
        PH_CH1  = 2'd2
    } phase_t;

    typedef struct packed {
        phase_t phase;
        logic   busy;
        logic   eoc_n;
        logic   req;
        logic   sel;
    } ctrl_state_t;

endpackage

// File: rtl/dual_conv_seq_ctrl.sv
module dual_conv_seq_ctrl
    import dual_conv_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic done_i,
    output logic take_hi_o,
    output logic take_lo_o,
    output logic req_o,
    output logic sel_o,
    output logic busy_o,
    output logic eoc_n_o
);

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.eoc_n = 1'b1;
        st_d.req   = 1'b0;
        take_hi_o  = 1'b0;
        take_lo_o  = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_CH0;
                    st_d.busy  = 1'b1;
                    st_d.req   = 1'b1;
                    st_d.sel   = 1'b0;
                end
            end
            PH_CH0: begin
                if (done_i) begin
                    take_hi_o  = 1'b1;
                    st_d.eoc_n = 1'b0;
                    st_d.phase = PH_CH1;
                    st_d.req   = 1'b1;
                    st_d.sel   = 1'b1;
                end
            end
            PH_CH1: begin
                if (done_i) begin
                    take_lo_o  = 1'b1;
                    st_d.eoc_n = 1'b0;
                    st_d.phase = PH_IDLE;
                    st_d.busy  = 1'b0;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_IDLE;
            st_q.busy  <= 1'b0;
            st_q.eoc_n <= 1'b1;
            st_q.req   <= 1'b0;
            st_q.sel   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o   = st_q.req;
    assign sel_o   = st_q.sel;
    assign busy_o  = st_q.busy;
    assign eoc_n_o = st_q.eoc_n;

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && req_o && !sel_o)); // R1
    AST_EOC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !eoc_n_o |=> eoc_n_o); // R3
    AST_HOLD_WHILE_WAITING: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_i) |=> (busy_o && $stable(sel_o) && eoc_n_o)); // R5
    AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> (!busy_o && eoc_n_o && !req_o)); // R6
    AST_CH1_REQUEST: assert property (@(posedge clk) disable iff (rst)
        ($rose(sel_o)) |-> (req_o && busy_o)); // R8

endmodule

// File: rtl/dual_conv_seq_capture.sv
module dual_conv_seq_capture #(
    parameter int DATA_W = 16,
    localparam int WORD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_hi_i,
    input  logic              take_lo_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              busy_i,
    output logic [WORD_W-1:0] word_o,
    output logic              load_o
);

    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [WORD_W-1:0] word;
        logic              load;
    } cap_state_t;

    cap_state_t cs_d, cs_q;

    always_comb begin
        cs_d      = cs_q;
        cs_d.load = take_lo_i;
        if (take_hi_i) cs_d.hi = data_i;
        if (take_lo_i) cs_d.word = {cs_q.hi, data_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q.hi   <= '0;
            cs_q.word <= '0;
            cs_q.load <= 1'b0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign word_o = cs_q.word;
    assign load_o = cs_q.load;

    AST_LOAD_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
        load_o |-> (!busy_i && $past(busy_i))); // R4
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        !load_o |=> (load_o || $stable(word_o))); // R4

endmodule

// File: rtl/dual_conv_seq.sv
module dual_conv_seq #(
    parameter int DATA_W = 16,
    localparam int WORD_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              conv_done_i,
    input  logic [DATA_W-1:0] conv_data_i,
    output logic              conv_req_o,
    output logic              conv_sel_o,
    output logic              busy_o,
    output logic              eoc_n_o,
    output logic [WORD_W-1:0] result_o,
    output logic              load_o
);

    logic take_hi, take_lo;

    dual_conv_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .done_i    (conv_done_i),
        .take_hi_o (take_hi),
        .take_lo_o (take_lo),
        .req_o     (conv_req_o),
        .sel_o     (conv_sel_o),
        .busy_o    (busy_o),
        .eoc_n_o   (eoc_n_o)
    );

    dual_conv_seq_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .take_hi_i (take_hi),
        .take_lo_i (take_lo),
        .data_i    (conv_data_i),
        .busy_i    (busy_o),
        .word_o    (result_o),
        .load_o    (load_o)
    );

endmodule

// File: tb/dual_conv_seq_test.sv
module dual_conv_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        conv_done_i = 1'b0;
    logic [15:0] conv_data_i = '0;
    logic        conv_req_o, conv_sel_o, busy_o, eoc_n_o, load_o;
    logic [31:0] result_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk; // 125 MHz

    dual_conv_seq uut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
        .conv_req_o(conv_req_o), .conv_sel_o(conv_sel_o),
        .busy_o(busy_o), .eoc_n_o(eoc_n_o),
        .result_o(result_o), .load_o(load_o)
    );

    // Reference model, updated at each rising edge from the sampled inputs
    int          m_phase = 0;
    logic        m_busy = 0, m_eoc_n = 1, m_req = 0, m_sel = 0, m_load = 0;
    logic [15:0] m_hi = '0;
    logic [31:0] m_word = '0;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_phase = 0; m_busy = 0; m_eoc_n = 1; m_req = 0; m_sel = 0;
            m_load = 0; m_hi = '0; m_word = '0;
        end else begin
            m_eoc_n = 1; m_req = 0; m_load = 0;
            case (m_phase)
                0: if (start_i) begin
                    m_phase = 1; m_busy = 1; m_req = 1; m_sel = 0;
                end
                1: if (conv_done_i) begin
                    m_hi = conv_data_i; m_eoc_n = 0; m_phase = 2;
                    m_req = 1; m_sel = 1;
                end
                default: if (conv_done_i) begin
                    m_word = {m_hi, conv_data_i}; m_load = 1; m_eoc_n = 0;
                    m_busy = 0; m_phase = 0;
                end
            endcase
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (cycles > 0) begin
            check("R2 busy", {31'd0, busy_o}, {31'd0, m_busy});
            check("R3 eoc_n", {31'd0, eoc_n_o}, {31'd0, m_eoc_n});
            check("R4 load", {31'd0, load_o}, {31'd0, m_load});
            check("R4 word", result_o, m_word);
            check("R1/R8 req", {31'd0, conv_req_o}, {31'd0, m_req});
            check("R8 sel", {31'd0, conv_sel_o}, {31'd0, m_sel});
        end
    end

    // Engine model: answers each request after eng_lat extra cycles
    int  eng_lat = 0;
    int  eng_cnt = 0;
    bit  eng_pend = 0;
    bit  force_done = 0;

    always @(negedge clk) begin
        conv_done_i <= 1'b0;
        if (force_done) begin
            conv_done_i <= 1'b1;
            conv_data_i <= 16'($urandom);
        end else if (eng_pend && eng_cnt == 0) begin
            conv_done_i <= 1'b1;
            conv_data_i <= 16'($urandom);
            eng_pend = 0;
        end else if (eng_pend) begin
            eng_cnt--;
        end
        if (conv_req_o && !rst) begin
            eng_pend = 1;
            eng_cnt = eng_lat;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    int eoc_count = 0;
    always @(negedge clk) if (!rst && eoc_n_o === 1'b0) eoc_count++;

    initial begin
        logic [31:0] saved;
        idle(3);
        check("R7 reset busy", {31'd0, busy_o}, 32'd0);
        check("R7 reset eoc_n", {31'd0, eoc_n_o}, 32'd1);
        check("R7 reset word", result_o, 32'd0);
        rst = 1'b0;
        idle(2);

        // R1: start from idle, several engine latencies
        for (int lat = 0; lat < 4; lat++) begin
            eng_lat = lat;
            eoc_count = 0;
            @(negedge clk); start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
            check("R1 busy after start", {31'd0, busy_o}, 32'd1);
            check("R1 sel ch0", {31'd0, conv_sel_o}, 32'd0);
            idle(2 * lat + 8);
            check("R3 two pulses", eoc_count, 32'd2);
            check("R2 idle after", {31'd0, busy_o}, 32'd0);
        end

        // R5: starts during busy are ignored
        eng_lat = 5;
        eoc_count = 0;
        pulse_start();
        idle(2);
        pulse_start();
        idle(5);
        pulse_start();
        idle(20);
        check("R5 only two pulses", eoc_count, 32'd2);

        // R6: stray done while idle
        saved = result_o;
        @(negedge clk); force_done = 1;
        @(negedge clk); force_done = 0;
        idle(3);
        check("R6 word unchanged", result_o, saved);
        check("R6 still idle", {31'd0, busy_o}, 32'd0);

        // R7: reset while waiting for channel 1
        eng_lat = 6;
        pulse_start();
        while (!(conv_req_o && conv_sel_o)) @(negedge clk);
        saved = result_o;
        idle(2);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(12);
        check("R7 abort idle", {31'd0, busy_o}, 32'd0);
        check("R7 word cleared", result_o, 32'd0);

        // Back-to-back sequences after abort
        eng_lat = 1;
        for (int k = 0; k < 5; k++) begin
            pulse_start();
            idle(6);
        end
        eng_lat = 0;
        @(negedge clk); start_i = 1'b1;
        idle(30);
        start_i = 1'b0;
        idle(5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule